// File: doc/BRIEF.md
# Three-Lane Multi-Format Serial Audio Receiver

This block takes three serial audio data lanes that share one bit clock and one frame (word-select) clock, and turns each lane into a pair of 24-bit two's-complement samples: one left and one right. That gives six channels per frame. The bit clock and frame clock arrive from outside and are oversampled by the faster system clock. Data is taken on each rising bit-clock edge.

A two-bit framing input chooses how words sit inside each word-select half. There are four choices: I2S, left-justified, right-justified with 24 valid bits, and right-justified with 20 valid bits. The framing input is held steady while the block is out of reset, and any change is made under reset. After the right-channel word of a frame ends, all six samples appear together on the outputs, and a strobe marks them for one system-clock cycle.

Top module: `serial_audio_rx`

## Requirements
- R1: A synchronous active-high `rst` clears all sample outputs to zero and holds `frame_valid` low. Both stay that way in the first cycle after `rst` falls.
- R2: With `mode` = 0 (I2S), word-select low carries the left word and high carries the right word. The MSB is the bit on the second rising bit-clock edge after a word-select change. The next 23 bits follow it.
- R3: With `mode` = 1 (left-justified), word-select high carries the left word and low carries the right word. The MSB is the bit on the first rising edge after a word-select change, followed by 23 more bits.
- R4: With `mode` = 2 (right-justified, 24-bit), the polarity is the same as R3. The word is the last 24 bits received before the word-select change, and the final one of them is the LSB.
- R5: With `mode` = 3 (right-justified, 20-bit), the polarity is the same as R3. The word is the last 20 bits before the word-select change. Bit 19 of that word is copied into output bits 23..20.
- R6: Bits in a half that lie outside the word position set by the mode have no effect on the samples.
- R7: Each completed frame raises `frame_valid` for exactly one system-clock cycle. This happens after the right-channel word has ended, which is detected at the next word-select change. The same cycle presents all six samples.
- R8: After reset, a half that was already under way when reception began is discarded. No strobe is raised until a left word and then a right word have both been received complete.
- R9: Lane k (`sdata[k]`) drives bits [24k+23:24k] of `left_out` and `right_out`. The lanes do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Framing select: 0 I2S, 1 left-justified, 2 right-justified 24-bit, 3 right-justified 20-bit |
| bclk | input | 1 | Serial bit clock (asynchronous) |
| ws | input | 1 | Word-select / frame clock (asynchronous) |
| sdata | input | 3 | Serial data, one bit per lane |
| left_out | output | 72 | Left samples, 24 bits per lane, lane 0 in the low bits |
| right_out | output | 72 | Right samples, 24 bits per lane, lane 0 in the low bits |
| frame_valid | output | 1 | One-cycle strobe when a new frame of samples is on the outputs |

## Verification
The embedded properties check several rules on every cycle. Outputs are clear right after reset. The strobe never lasts longer than one cycle and only follows a detected bit-clock edge. In 20-bit mode, the upper output bits of the right samples always equal the sign bit. Only the bench can show that the word bits are picked correctly for each framing and polarity. It does this by sending random words with random half lengths and random padding, plus directed full-scale words. It also shows that a partial first half after reset produces no frame, and that each lane lands in its own output slice.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S      = 2'd0,
    FMT_LJ       = 2'd1,
    FMT_RJ_FULL  = 2'd2,
    FMT_RJ_SHORT = 2'd3
  } fmt_e;
endpackage

// File: rtl/sarx_sync.sv
// Brings the asynchronous serial pins into the clk domain and flags rising
// bit-clock edges. All pins pass through the same depth so they stay aligned.
module sarx_sync #(
  parameter int LANES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_in,
  input  logic             ws_in,
  input  logic [LANES-1:0] sd_in,
  output logic             rise,
  output logic             ws_s,
  output logic [LANES-1:0] sd_s
);
  logic             b_pipe [STAGES];
  logic             w_pipe [STAGES];
  logic [LANES-1:0] d_pipe [STAGES];
  logic             b_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) begin
        b_pipe[i] <= 1'b0;
        w_pipe[i] <= 1'b0;
        d_pipe[i] <= '0;
      end
      b_last <= 1'b0;
    end else begin
      b_pipe[0] <= bclk_in;
      w_pipe[0] <= ws_in;
      d_pipe[0] <= sd_in;
      for (int i = 1; i < STAGES; i++) begin
        b_pipe[i] <= b_pipe[i-1];
        w_pipe[i] <= w_pipe[i-1];
        d_pipe[i] <= d_pipe[i-1];
      end
      b_last <= b_pipe[STAGES-1];
    end
  end

  assign rise = b_pipe[STAGES-1] & ~b_last;
  assign ws_s = w_pipe[STAGES-1];
  assign sd_s = d_pipe[STAGES-1];
endmodule

// File: rtl/sarx_framer.sv
// Tracks the bit position inside each word-select half and decides when the
// lanes shift, when a left word is captured and when a frame is released.
module sarx_framer
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 6
) (
  input  logic clk,
  input  logic rst,
  input  fmt_e fmt,
  input  logic rise,
  input  logic ws_s,
  output logic shift_en,
  output logic cap_left,
  output logic emit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] WORD_C  = CNT_W'(SAMPLE_W);

  logic             primed, started, have_left, ws_prev;
  logic [CNT_W-1:0] pos, pos_cur;
  logic             change, prev_left, in_win;

  always_comb begin
    change    = rise && primed && (ws_s != ws_prev);
    pos_cur   = change ? '0 : pos;
    prev_left = (fmt == FMT_I2S) ? ~ws_prev : ws_prev;
    case (fmt)
      FMT_I2S: in_win = (pos_cur != '0) && (pos_cur <= WORD_C);
      FMT_LJ:  in_win = (pos_cur < WORD_C);
      default: in_win = 1'b1;  // right-justified: keep the newest bits
    endcase
    shift_en = rise && in_win;
    cap_left = change && started && prev_left;
    emit     = change && started && !prev_left && have_left;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed    <= 1'b0;
      started   <= 1'b0;
      have_left <= 1'b0;
      ws_prev   <= 1'b0;
      pos       <= '0;
    end else if (rise) begin
      primed  <= 1'b1;
      ws_prev <= ws_s;
      pos     <= (pos_cur == CNT_MAX) ? CNT_MAX : pos_cur + 1'b1;
      if (change) started <= 1'b1;
      if (cap_left)  have_left <= 1'b1;
      else if (emit) have_left <= 1'b0;
    end
  end
endmodule

// File: rtl/sarx_lane.sv
// One serial lane: shift register, left hold and registered sample outputs.
module sarx_lane
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  fmt_e                fmt,
  input  logic                sd,
  input  logic                shift_en,
  input  logic                cap_left,
  input  logic                emit,
  output logic [SAMPLE_W-1:0] left_q,
  output logic [SAMPLE_W-1:0] right_q
);
  localparam int EXT_W = SAMPLE_W - SHORT_W;

  logic [SAMPLE_W-1:0] sreg, left_hold, word;

  always_comb begin
    if (fmt == FMT_RJ_SHORT)
      word = {{EXT_W{sreg[SHORT_W-1]}}, sreg[SHORT_W-1:0]};
    else
      word = sreg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg      <= '0;
      left_hold <= '0;
      left_q    <= '0;
      right_q   <= '0;
    end else begin
      if (shift_en) sreg <= {sreg[SAMPLE_W-2:0], sd};
      if (cap_left) left_hold <= word;
      if (emit) begin
        left_q  <= left_hold;
        right_q <= word;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int LANES    = 3,
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 20,
  parameter int SYNC_STG = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                mode,
  input  logic                      bclk,
  input  logic                      ws,
  input  logic [LANES-1:0]          sdata,
  output logic [LANES*SAMPLE_W-1:0] left_out,
  output logic [LANES*SAMPLE_W-1:0] right_out,
  output logic                      frame_valid
);
  localparam int CNT_W = $clog2(SAMPLE_W + 2) + 1;
  localparam int EXT_W = SAMPLE_W - SHORT_W + 1;

  fmt_e             fmt;
  logic             rise, ws_s, shift_en, cap_left, emit;
  logic [LANES-1:0] sd_s;

  assign fmt = fmt_e'(mode);

  sarx_sync #(.LANES(LANES), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .bclk_in(bclk), .ws_in(ws), .sd_in(sdata),
    .rise(rise), .ws_s(ws_s), .sd_s(sd_s)
  );

  sarx_framer #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst(rst), .fmt(fmt), .rise(rise), .ws_s(ws_s),
    .shift_en(shift_en), .cap_left(cap_left), .emit(emit)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sarx_lane #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_lane (
      .clk(clk), .rst(rst), .fmt(fmt), .sd(sd_s[l]),
      .shift_en(shift_en), .cap_left(cap_left), .emit(emit),
      .left_q(left_out[l*SAMPLE_W +: SAMPLE_W]),
      .right_q(right_out[l*SAMPLE_W +: SAMPLE_W])
    );

    // R5: short right-justified samples carry their sign into the top bits
    p_short_sext_r5: assert property (@(posedge clk) disable iff (rst)
      (frame_valid && fmt == FMT_RJ_SHORT) |->
        (right_out[l*SAMPLE_W+SHORT_W-1 +: EXT_W] == '0 ||
         right_out[l*SAMPLE_W+SHORT_W-1 +: EXT_W] == '1));
  end

  always_ff @(posedge clk) begin
    if (rst) frame_valid <= 1'b0;
    else     frame_valid <= emit;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!frame_valid && left_out == '0 && right_out == '0));

  p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  p_valid_after_edge_r7: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> $past(rise));
endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
  localparam int LANES = 3;
  localparam int W     = 24;
  localparam int TW    = LANES * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mode = 2'd0;
  logic          bclk = 1'b0;
  logic          ws = 1'b0;
  logic [LANES-1:0] sdata = '0;
  logic [TW-1:0] left_out, right_out;
  logic          frame_valid;

  always #4 clk = ~clk;  // 125 MHz

  serial_audio_rx uut (
    .clk(clk), .rst(rst), .mode(mode), .bclk(bclk), .ws(ws), .sdata(sdata),
    .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
  );

  int errors = 0;
  int checks = 0;
  int n_exp = 0;
  int n_got = 0;
  int pulse_len = 0;
  string tag = "R1";
  logic [TW-1:0] exp_l [0:31];
  logic [TW-1:0] exp_r [0:31];

  task automatic check(string req, logic [TW-1:0] act, logic [TW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Bit for position p of a half of length len, per the framing rules.
  function automatic logic bit_for(logic [1:0] m, logic [W-1:0] w, int p, int len);
    case (m)
      2'd0: if (p >= 1 && p <= 24) return w[24-p];          // R2
      2'd1: if (p < 24) return w[23-p];                     // R3
      2'd2: if (p >= len - 24) return w[len-1-p];           // R4
      default: if (p >= len - 20) return w[len-1-p];        // R5
    endcase
    return 1'($urandom);                                   // R6 padding
  endfunction

  function automatic logic [W-1:0] expect_word(logic [1:0] m, logic [W-1:0] w);
    return (m == 2'd3) ? {{4{w[19]}}, w[19:0]} : w;
  endfunction

  function automatic logic [TW-1:0] rand_words();
    logic [TW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*W +: W] = W'($urandom);
    return v;
  endfunction

  function automatic logic [TW-1:0] expect_all(logic [1:0] m, logic [TW-1:0] v);
    logic [TW-1:0] e;
    for (int l = 0; l < LANES; l++) e[l*W +: W] = expect_word(m, v[l*W +: W]);
    return e;
  endfunction

  task automatic send_bit(logic wsv, logic [LANES-1:0] d);
    @(negedge clk);
    ws = wsv;
    sdata = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    bclk = 1'b0;
  endtask

  task automatic send_half(logic wsv, logic [TW-1:0] words, int len);
    for (int p = 0; p < len; p++) begin
      logic [LANES-1:0] d;
      for (int l = 0; l < LANES; l++) d[l] = bit_for(mode, words[l*W +: W], p, len);
      send_bit(wsv, d);
    end
  endtask

  function automatic int half_len(logic [1:0] m);
    return (m == 2'd0) ? 25 + int'($urandom % 8) : 24 + int'($urandom % 9);
  endfunction

  task automatic do_reset(logic [1:0] m);
    @(negedge clk);
    rst = 1'b1;
    mode = m;
    bclk = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n_exp = 0;
    n_got = 0;
    @(negedge clk);
    check("R1 valid", TW'(frame_valid), '0);
    check("R1 left", left_out, '0);
    check("R1 right", right_out, '0);
  endtask

  // Monitor: compare every strobe against the expected frame queue (R7, R9).
  always @(negedge clk) begin
    if (frame_valid) begin
      pulse_len++;
      if (pulse_len == 1) begin
        if (n_got < n_exp) begin
          check({tag, " left R9"}, left_out, exp_l[n_got]);
          check({tag, " right R9"}, right_out, exp_r[n_got]);
        end else begin
          check("R8 unexpected strobe", TW'(n_got), TW'(n_exp));
        end
        n_got++;
      end else begin
        check("R7 strobe width", TW'(pulse_len), TW'(1));
      end
    end else begin
      pulse_len = 0;
    end
  end

  task automatic run_mode(logic [1:0] m, string t, int nframes);
    logic left_lvl;
    do_reset(m);
    tag = t;
    left_lvl = (m == 2'd0) ? 1'b0 : 1'b1;
    send_half(~left_lvl, rand_words(), 9);  // partial half, discarded (R8)
    for (int f = 0; f < nframes; f++) begin
      logic [TW-1:0] lw, rw;
      lw = rand_words();
      rw = rand_words();
      if (f == 0) begin
        lw = {LANES{24'h800000}};
        rw = {LANES{24'h7FFFFF}};
      end else if (f == 1) begin
        lw = {LANES{24'h080000}};
        rw = {LANES{24'h07FFFF}};
      end
      exp_l[n_exp] = expect_all(m, lw);
      exp_r[n_exp] = expect_all(m, rw);
      n_exp++;
      send_half(left_lvl, lw, half_len(m));
      send_half(~left_lvl, rw, half_len(m));
    end
    send_half(left_lvl, rand_words(), 3);   // closes the last right word
    repeat (20) @(negedge clk);
    check({t, " R7 frame count"}, TW'(n_got), TW'(n_exp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check("R1 valid at start", TW'(frame_valid), '0);
    check("R1 left at start", left_out, '0);

    run_mode(2'd0, "R2 (R6)", 7);
    run_mode(2'd1, "R3 (R6)", 7);
    run_mode(2'd2, "R4 (R6)", 7);
    run_mode(2'd3, "R5 (R6)", 7);

    // R8: start inside a left half; the following right half must not strobe.
    do_reset(2'd1);
    tag = "R8";
    send_half(1'b1, rand_words(), 12);
    send_half(1'b0, rand_words(), 32);
    repeat (20) @(negedge clk);
    check("R8 no strobe after partial left", TW'(n_got), '0);
    begin
      logic [TW-1:0] lw, rw;
      lw = rand_words();
      rw = rand_words();
      exp_l[n_exp] = lw;
      exp_r[n_exp] = rw;
      n_exp++;
      send_half(1'b1, lw, 32);
      send_half(1'b0, rw, 32);
      send_half(1'b1, rand_words(), 2);
    end
    repeat (20) @(negedge clk);
    check("R8 one frame after full pair", TW'(n_got), TW'(1));

    // R1: reset in mid-stream clears non-zero outputs.
    do_reset(2'd2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule